// File: doc/BRIEF.md
# Programmable CRC Engine with Seed Load

This block is a register-mapped CRC accelerator. Software programs a generator polynomial and selects either a 16-bit or a 32-bit checksum width. It then loads a starting value and streams message data through a single data register. Each write to that register carries one to four bytes, chosen by the byte enables. The enabled bytes are folded into the running checksum in one clock cycle. The most significant enabled byte goes in first, and each byte is shifted in MSB-first with no bit reflection.

One control flag changes how the data register treats writes. When the flag is set, a write to the data register loads the seed instead of adding message data. Reading the data register at any time returns the running checksum, so the final result needs no extra step. There is no final inversion and no bit or byte reordering. In 16-bit mode the checksum lives in the low half of the data register, and the upper half keeps whatever it last held.

Top module: `crc_engine`

## Requirements
- R1: After reset the data register reads 0xFFFF_FFFF, the polynomial register reads 0x0000_1021 and the control register reads 0x0000_0000.
- R2: Registers sit at byte address 0x0 (data/checksum), 0x4 (polynomial) and 0x8 (control). Any other address reads as zero, and writes to it change no register.
- R3: Control bit 24 selects the width (0 = 16-bit, 1 = 32-bit) and control bit 25 is the seed-load flag. Both are written through byte lane 3, and every other control bit reads as zero.
- R4: Polynomial writes update only the byte lanes whose enable is set. Byte enable bit n covers data bits 8n+7..8n.
- R5: In 32-bit mode with the seed flag set, each enabled byte lane of a data write replaces the same byte of the checksum.
- R6: In 16-bit mode with the seed flag set, only lanes 0 and 1 of a data write load the seed. Bits 31..16 of the data register are left unchanged.
- R7: In 32-bit mode with the seed flag clear, each data byte b updates the checksum c as follows: c is XORed with b<<24, then shifted left 8 times. On each shift, if the bit leaving position 31 is 1, the result is XORed with the full polynomial.
- R8: In 16-bit mode with the seed flag clear, the same update runs on bits 15..0 using polynomial bits 15..0 and bit 15 as the outgoing bit. Bits 31..16 of the data register are left unchanged.
- R9: A write with several contiguous enabled lanes processes them from the highest lane down to the lowest. The result equals separate single-byte writes made in that order.
- R10: The update from a data write is visible on a read of the data register in the cycle after the write.
- R11: A data-register write whose byte enables are non-zero but not one contiguous run changes nothing.
- R12: A data-register write with all byte enables clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_be | input | 4 | Byte lane enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest states to reach come from data writes that mix unusual byte-enable patterns with mode changes in the middle of a stream. Examples are a non-contiguous pattern arriving right after a seed load, or a switch from 32-bit to 16-bit mode that leaves stale upper bytes behind. Most such patterns never appear in normal driver traffic. The stimulus therefore draws byte enables from all sixteen patterns and toggles the width and seed flags at random between data writes. Directed runs over the standard check string pin down the byte order and the polynomial arithmetic in both widths.

// File: rtl/crc_engine_pkg.sv
// Package: shared constants and helpers for the CRC engine.
// Assumes a 32-bit register bus carrying four byte lanes.
package crc_engine_pkg;

    localparam int BUS_BYTES    = 4;
    localparam int BUS_W        = BUS_BYTES * 8;
    localparam int NARROW_W     = 16;
    localparam int NARROW_BYTES = NARROW_W / 8;

    // Register byte offsets
    localparam int OFF_DATA = 'h0;
    localparam int OFF_POLY = 'h4;
    localparam int OFF_CTRL = 'h8;

    // Control bit positions
    localparam int CTRL_WIDE_BIT = 24;
    localparam int CTRL_SEED_BIT = 25;

    // True when the enables form exactly one non-empty run of adjacent lanes
    function automatic logic be_contiguous(input logic [BUS_BYTES-1:0] be);
        int runs;
        runs = 0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (be[i] && ((i == BUS_BYTES - 1) || !be[(i + 1) % BUS_BYTES]))
                runs++;
        end
        return (runs == 1);
    endfunction

endpackage

// File: rtl/crc_byte_step.sv
// Module: crc_byte_step
// Folds one byte into a checksum, MSB-first with no reflection.
// Wide mode uses all 32 bits of the state and the polynomial. Narrow
// mode works on the low 16 bits and passes the upper half through.
// Purely combinational.
module crc_byte_step
    import crc_engine_pkg::*;
(
    input  logic [BUS_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    input  logic [BUS_W-1:0] poly,
    input  logic             wide,
    output logic [BUS_W-1:0] crc_out
);

    logic [BUS_W-1:0]    acc_wide;
    logic [NARROW_W-1:0] acc_narrow;

    // Eight shift/reduce steps in both widths, then pick by mode
    always_comb begin
        acc_wide   = crc_in ^ {byte_in, {(BUS_W - 8){1'b0}}};
        acc_narrow = crc_in[NARROW_W-1:0] ^ {byte_in, {(NARROW_W - 8){1'b0}}};
        for (int b = 0; b < 8; b++) begin
            if (acc_wide[BUS_W-1])
                acc_wide = (acc_wide << 1) ^ poly;
            else
                acc_wide = acc_wide << 1;
            if (acc_narrow[NARROW_W-1])
                acc_narrow = (acc_narrow << 1) ^ poly[NARROW_W-1:0];
            else
                acc_narrow = acc_narrow << 1;
        end
        crc_out = wide ? acc_wide : {crc_in[BUS_W-1:NARROW_W], acc_narrow};
    end

endmodule

// File: rtl/crc_lane_chain.sv
// Module: crc_lane_chain
// Chains one byte-step per lane, from the highest lane to the lowest.
// Lanes whose enable is clear pass the state through unchanged.
// Assumes the caller has already checked that the enables are contiguous,
// so the enabled lanes are handled most significant first.
module crc_lane_chain
    import crc_engine_pkg::*;
#(
    parameter int LANES = BUS_BYTES
) (
    input  logic [BUS_W-1:0] crc_in,
    input  logic [BUS_W-1:0] data_in,
    input  logic [LANES-1:0] lane_en,
    input  logic [BUS_W-1:0] poly,
    input  logic             wide,
    output logic [BUS_W-1:0] crc_out
);

    logic [BUS_W-1:0] stage_crc [LANES+1];

    assign stage_crc[0] = crc_in;

    for (genvar s = 0; s < LANES; s++) begin : g_stage
        localparam int LANE = LANES - 1 - s;
        logic [BUS_W-1:0] stepped;

        crc_byte_step u_step (
            .crc_in  (stage_crc[s]),
            .byte_in (data_in[LANE*8 +: 8]),
            .poly    (poly),
            .wide    (wide),
            .crc_out (stepped)
        );

        // Take the stepped value only when this lane is enabled
        assign stage_crc[s+1] = lane_en[LANE] ? stepped : stage_crc[s];
    end

    assign crc_out = stage_crc[LANES];

endmodule

// File: rtl/crc_engine.sv
// Module: crc_engine (top)
// Register-mapped CRC engine with a data/checksum register, a polynomial
// register and a control register (width and seed-load flags).
// Assumes a single-cycle write bus. Reads are combinational on the
// address. A data write takes effect at the next rising clock edge.
module crc_engine
    import crc_engine_pkg::*;
#(
    parameter int               ADDR_W     = 4,
    parameter logic [BUS_W-1:0] SEED_RESET = 32'hFFFF_FFFF,
    parameter logic [BUS_W-1:0] POLY_RESET = 32'h0000_1021
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_BYTES-1:0] bus_be,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata
);

    localparam int CTRL_LANE = CTRL_WIDE_BIT / 8;

    logic [BUS_W-1:0] crc_q;
    logic [BUS_W-1:0] poly_q;
    logic             ctrl_seed_q;
    logic             ctrl_wide_q;

    logic             hit_data;
    logic             hit_poly;
    logic             hit_ctrl;
    logic             be_ok;
    logic [BUS_W-1:0] seed_val;
    logic [BUS_W-1:0] calc_val;
    logic [BUS_W-1:0] poly_d;
    logic [BUS_W-1:0] ctrl_view;

    // Address decode for the three registers
    assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));
    assign hit_poly = (bus_addr == ADDR_W'(OFF_POLY));
    assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign be_ok    = be_contiguous(bus_be);

    // Seed merge: a lane loads only if enabled and within the active width
    for (genvar l = 0; l < BUS_BYTES; l++) begin : g_seed
        localparam bit ALWAYS_IN = (l < NARROW_BYTES);
        assign seed_val[l*8 +: 8] =
            (bus_be[l] && (ctrl_wide_q || ALWAYS_IN)) ? bus_wdata[l*8 +: 8]
                                                      : crc_q[l*8 +: 8];
    end

    crc_lane_chain #(
        .LANES (BUS_BYTES)
    ) u_chain (
        .crc_in  (crc_q),
        .data_in (bus_wdata),
        .lane_en (bus_be),
        .poly    (poly_q),
        .wide    (ctrl_wide_q),
        .crc_out (calc_val)
    );

    // Byte-masked next polynomial value
    always_comb begin
        poly_d = poly_q;
        for (int l = 0; l < BUS_BYTES; l++) begin
            if (bus_be[l])
                poly_d[l*8 +: 8] = bus_wdata[l*8 +: 8];
        end
    end

    // Checksum state: seed load or calculation on a valid data write
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= SEED_RESET;
        else if (bus_we && hit_data && be_ok)
            crc_q <= ctrl_seed_q ? seed_val : calc_val;
    end

    // Polynomial register with byte-lane writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            poly_q <= POLY_RESET;
        else if (bus_we && hit_poly)
            poly_q <= poly_d;
    end

    // Control flags, written through the lane that holds them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_seed_q <= 1'b0;
            ctrl_wide_q <= 1'b0;
        end else if (bus_we && hit_ctrl && bus_be[CTRL_LANE]) begin
            ctrl_seed_q <= bus_wdata[CTRL_SEED_BIT];
            ctrl_wide_q <= bus_wdata[CTRL_WIDE_BIT];
        end
    end

    // Control register as seen on reads; reserved bits are zero
    always_comb begin
        ctrl_view                = '0;
        ctrl_view[CTRL_SEED_BIT] = ctrl_seed_q;
        ctrl_view[CTRL_WIDE_BIT] = ctrl_wide_q;
    end

    // Read multiplexer; unmapped addresses return zero
    always_comb begin
        if (hit_data)
            bus_rdata = crc_q;
        else if (hit_poly)
            bus_rdata = poly_q;
        else if (hit_ctrl)
            bus_rdata = ctrl_view;
        else
            bus_rdata = '0;
    end

endmodule

// File: rtl/crc_engine_chk.sv
// Module: crc_engine_chk
// Property checker for crc_engine, attached with the bind below.
// Watches the bus and the checksum state and decodes byte enables itself.
module crc_engine_chk
    import crc_engine_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [BUS_BYTES-1:0] bus_be,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [BUS_W-1:0]     crc_q,
    input logic                 seed_on,
    input logic                 wide_on
);

    logic data_wr;
    logic mapped;
    logic single_run;
    int   run_starts;

    assign data_wr = bus_we && (bus_addr == ADDR_W'(OFF_DATA));
    assign mapped  = (bus_addr == ADDR_W'(OFF_DATA)) || (bus_addr == ADDR_W'(OFF_POLY))
                  || (bus_addr == ADDR_W'(OFF_CTRL));

    // Count the lanes that begin a run of enabled lanes
    always_comb begin
        run_starts = 0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (bus_be[i] && (i == 0 || !bus_be[(i + BUS_BYTES - 1) % BUS_BYTES]))
                run_starts++;
        end
        single_run = (run_starts == 1);
    end

    a_r11_noncontig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && bus_be != '0 && !single_run) |=> $stable(crc_q));

    a_r12_empty_be_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && bus_be == '0) |=> $stable(crc_q));

    a_r6_seed16_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seed_on && !wide_on) |=> (crc_q[31:16] == $past(crc_q[31:16])));

    a_r8_calc16_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !seed_on && !wide_on) |=> (crc_q[31:16] == $past(crc_q[31:16])));

    a_r5_seed32_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seed_on && wide_on && bus_be == '1) |=> (crc_q == $past(bus_wdata)));

    a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));

    a_r3_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTRL)) |->
            ((bus_rdata & ~((32'h1 << CTRL_SEED_BIT) | (32'h1 << CTRL_WIDE_BIT))) == '0));

endmodule

bind crc_engine crc_engine_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .crc_q     (crc_q),
    .seed_on   (ctrl_seed_q),
    .wide_on   (ctrl_wide_q)
);

// File: tb/crc_engine_test.sv
// Bench for crc_engine: directed corner cases plus seeded random traffic,
// checked against a reference model kept in bench variables.
`timescale 1ns/1ps
module crc_engine_test;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_crc  = 32'hFFFF_FFFF;
    logic [31:0] m_poly = 32'h0000_1021;
    logic        m_seed = 1'b0;
    logic        m_wide = 1'b0;

    always #(HALF) clk = ~clk;

    crc_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b,
                                             input logic [31:0] p, input logic w);
        logic [15:0] n;
        if (w) begin
            c = c ^ {b, 24'h0};
            for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ p) : (c << 1);
            return c;
        end
        n = c[15:0] ^ {b, 8'h0};
        for (int k = 0; k < 8; k++) n = n[15] ? ((n << 1) ^ p[15:0]) : (n << 1);
        return {c[31:16], n};
    endfunction

    function automatic bit ref_contig(input logic [3:0] be);
        case (be)
            4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b0110,
            4'b1100, 4'b0111, 4'b1110, 4'b1111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Apply a write to the model
    task automatic model_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        if (a == 4'h0) begin
            if (!ref_contig(be)) return;
            if (m_seed) begin
                for (int l = 0; l < 4; l++)
                    if (be[l] && (m_wide || l < 2)) m_crc[l*8 +: 8] = d[l*8 +: 8];
            end else begin
                for (int l = 3; l >= 0; l--)
                    if (be[l]) m_crc = ref_step(m_crc, d[l*8 +: 8], m_poly, m_wide);
            end
        end else if (a == 4'h4) begin
            for (int l = 0; l < 4; l++)
                if (be[l]) m_poly[l*8 +: 8] = d[l*8 +: 8];
        end else if (a == 4'h8) begin
            if (be[3]) begin
                m_seed = d[25];
                m_wide = d[24];
            end
        end
    endtask

    // One bus write, applied at a falling edge and committed at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
        model_write(a, be, d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] m_ctrl();
        return {6'b0, m_seed, m_wide, 24'h0};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        string msg = "123456789";

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(4'h0, v); check("R1 data reset", v, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R1 poly reset", v, 32'h0000_1021);
        rd(4'h8, v); check("R1 ctrl reset", v, 32'h0000_0000);

        // R2 unmapped address
        rd(4'hC, v); check("R2 unmapped read", v, 32'h0);
        wr(4'hC, 4'hF, 32'h1234_5678);
        rd(4'h0, v); check("R2 data after unmapped write", v, m_crc);
        rd(4'h4, v); check("R2 poly after unmapped write", v, m_poly);

        // R3 control field positions
        wr(4'h8, 4'hF, 32'hFFFF_FFFF);
        rd(4'h8, v); check("R3 ctrl reserved bits", v, 32'h0300_0000);
        wr(4'h8, 4'h7, 32'h0000_0000);
        rd(4'h8, v); check("R3 ctrl needs lane 3", v, 32'h0300_0000);
        wr(4'h8, 4'h8, 32'h0000_0000);
        rd(4'h8, v); check("R3 ctrl cleared", v, 32'h0);

        // R4 polynomial byte lanes
        wr(4'h4, 4'h1, 32'hEEEE_EEAB);
        rd(4'h4, v); check("R4 poly lane 0", v, 32'h0000_10AB);
        wr(4'h4, 4'h3, 32'h0000_1021);
        rd(4'h4, v); check("R4 poly restore", v, 32'h0000_1021);

        // R6 16-bit seed keeps the upper half; R8 standard 16-bit check value
        wr(4'h8, 4'h8, 32'h0200_0000);
        wr(4'h0, 4'hF, 32'hAAAA_FFFF);
        rd(4'h0, v); check("R6 seed16 upper kept", v, 32'hFFFF_FFFF);
        wr(4'h8, 4'h8, 32'h0000_0000);
        for (int i = 0; i < 9; i++) wr(4'h0, 4'h1, {24'h0, msg[i]});
        rd(4'h0, v); check("R8 crc16 check value", v, 32'hFFFF_29B1);

        // R5 32-bit seed, R7/R9 standard 32-bit check value via mixed widths
        wr(4'h8, 4'h8, 32'h0300_0000);
        wr(4'h4, 4'hF, 32'h04C1_1DB7);
        wr(4'h0, 4'hF, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R5 seed32", v, 32'hFFFF_FFFF);
        wr(4'h8, 4'h8, 32'h0100_0000);
        wr(4'h0, 4'hF, 32'h3132_3334);
        wr(4'h0, 4'hC, 32'h3536_0000);
        wr(4'h0, 4'h3, 32'h0000_3738);
        wr(4'h0, 4'h2, 32'h0000_3900);
        rd(4'h0, v); check("R7 R9 crc32 check value", v, 32'h0376_E6E7);

        // R9 middle-lane pair matches two single-byte steps
        wr(4'h0, 4'h6, 32'h00AB_CD00);
        rd(4'h0, v); check("R9 lanes 2 then 1", v,
                           ref_step(ref_step(32'h0376_E6E7, 8'hAB, 32'h04C1_1DB7, 1'b1),
                                    8'hCD, 32'h04C1_1DB7, 1'b1));

        // R10 result readable in the cycle right after the write
        wr(4'h0, 4'h8, 32'h5A00_0000);
        rd(4'h0, v); check("R10 next-cycle read", v, m_crc);

        // R11 non-contiguous enables, R12 empty enables
        wr(4'h0, 4'h5, 32'h1111_1111);
        rd(4'h0, v); check("R11 noncontig ignored", v, m_crc);
        wr(4'h0, 4'h9, 32'h2222_2222);
        rd(4'h0, v); check("R11 noncontig 1001 ignored", v, m_crc);
        wr(4'h0, 4'h0, 32'h3333_3333);
        rd(4'h0, v); check("R12 empty be ignored", v, m_crc);

        // Random traffic with a fixed seed
        void'($urandom(32'd7321));
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [3:0] be;
            logic [31:0] d;
            op = $urandom % 10;
            be = 4'($urandom);
            d  = $urandom;
            if (op < 6) begin
                wr(4'h0, be, d);
                rd(4'h0, v);
                if (!ref_contig(be))     check(be == 0 ? "R12 random" : "R11 random", v, m_crc);
                else if (m_seed)         check(m_wide ? "R5 random" : "R6 random", v, m_crc);
                else                     check(m_wide ? "R7 random" : "R8 random", v, m_crc);
            end else if (op < 8) begin
                wr(4'h8, be, d);
                rd(4'h8, v); check("R3 random ctrl", v, m_ctrl());
            end else if (op < 9) begin
                wr(4'h4, be, d);
                rd(4'h4, v); check("R4 random poly", v, m_poly);
            end else begin
                wr(4'h0 + 4'(($urandom % 3) * 4 + 1), be, d);
                rd(4'h0, v); check("R2 random unaligned", v, m_crc);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule